// File: doc/BRIEF.md
# Address Bus Arbiter with Retry Handling

This block decides which master on a shared multi-master bus owns the address phase. Each master raises a request line. The arbiter answers with a registered one-hot grant. It uses a round-robin order that is held as a queue of master indices. A master that starts an address tenure moves to the tail of that queue.

A master may also raise a repeat hint to keep the bus for back-to-back tenures. A bounded counter limits how many repeats it gets. When no master is requesting, the bus can be parked on a configured master. That master may then start a tenure without first raising its request.

An address tenure can be aborted by a retry. The cycle after a retry is a retry window with its own rules:
- If the processor (master `CPU_ID`) caused the retry, it is granted at once for its copyback. When the copyback ends, the grant goes back to the master whose tenure was retried.
- If anyone else caused the retry, the retried master drops to the tail of the queue. The window arbitrates normally, but the regular parking policy does not apply. During the window the bus is either parked on the processor or left unparked, as configured.

The controller has four states:
- `ST_IDLE`: no owner, or the bus is parked.
- `ST_OWN`: a requester holds the grant and has not yet started its tenure.
- `ST_WIN`: the retry window.
- `ST_CB`: the processor holds the bus for its copyback.

The transitions are:
- IDLE→OWN: a request is seen.
- IDLE→IDLE: no request, or the parked master starts a tenure with no other request pending.
- OWN→OWN: tenure start with a repeat kept, or with a new winner.
- OWN→IDLE: tenure start with no request pending.
- IDLE/OWN→WIN: a retry caused by anyone other than the processor.
- IDLE/OWN→CB: a retry caused by the processor.
- WIN→OWN: a request is seen in the window.
- WIN→IDLE: no request in the window.
- CB→OWN: copyback done.

Top module: `aba_arbiter`

## Requirements
- R1: `gnt` is zero in reset and has at most one bit set at all times.
- R2: Priority starts at ascending index (master 0 highest). The winner is the first requesting master in the queue. Whenever a granted master starts a tenure without a kept repeat, it moves to the tail of the queue before the next winner is chosen.
- R3: Once a requesting master is granted (`ST_OWN`), the grant does not change until that master starts a tenure (`ten_start`) or a retry occurs.
- R4: On a tenure start, the owner keeps the grant without rotating if it still requests, has its `rpt_hint` bit set, and the repeat counter is nonzero. The counter is decremented on each kept repeat and reloaded from `cfg_rpt_limit` whenever the grant moves to a different master. A limit of 0 disables repeats.
- R5: In `ST_IDLE` with no request, `gnt` is the one-hot of `cfg_park_id` when `cfg_park_en` is 1, else zero. A parked master may start a tenure without requesting, and it then rotates like any other tenure.
- R6: A retry in `ST_IDLE`/`ST_OWN` with `retry_by_cpu`=0 moves the master of the last started tenure to the tail. It also sets `gnt` for the window cycle to the processor's bit if `cfg_win_park_cpu`=1, else to zero.
- R7: In the retry window, a request produces a grant to the queue winner. With no request, the arbiter falls back to regular parking in the following cycle.
- R8: A retry with `retry_by_cpu`=1 grants the processor in the next cycle. That grant holds until `cb_done`, after which the master of the retried tenure is granted. Tenure starts during the copyback do not rotate the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_MST | Request line per master |
| rpt_hint | input | N_MST | Repeat hint per master |
| ten_start | input | 1 | Granted master starts an address tenure this cycle |
| retry | input | 1 | The last address tenure is aborted |
| retry_by_cpu | input | 1 | Qualifies `retry`: the processor caused it |
| cb_done | input | 1 | Processor copyback finished |
| cfg_park_en | input | 1 | Enable regular parking |
| cfg_park_id | input | IDW | Master to park on |
| cfg_rpt_limit | input | RPT_W | Maximum kept repeats per ownership |
| cfg_win_park_cpu | input | 1 | Park on the processor during the retry window |
| gnt | output | N_MST | One-hot address grant |

## Verification
The assertions assume the following about the inputs:
- `ten_start` is only raised while a grant is held.
- `retry` only arrives in `ST_IDLE` or `ST_OWN`, after at least one tenure has started.
- `cb_done` only follows a processor retry.
- In the retry window, only the master that caused the retry keeps requesting.

The vector table and the directed tests raise each of these inputs only in such cycles. Each retry is placed right after a tenure start, so the retried master is known.

// File: rtl/aba_pkg.sv
package aba_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OWN  = 2'd1,
        ST_WIN  = 2'd2,
        ST_CB   = 2'd3
    } aba_state_e;
endpackage

// File: rtl/aba_prio_queue.sv
module aba_prio_queue #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mv_en,
    input  logic [IDW-1:0]          mv_id,
    output logic [N-1:0][IDW-1:0]   order_after
);
    logic [N-1:0][IDW-1:0] order_q;
    logic [N-1:0]          seen;
    logic [N-1:0]          present;

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < N; i++) begin
            acc     = acc | (order_q[i] == mv_id);
            seen[i] = acc;
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_slot
        if (s == N - 1) begin : g_tail
            assign order_after[s] = (mv_en && seen[s]) ? mv_id : order_q[s];
        end else begin : g_body
            assign order_after[s] = (mv_en && seen[s]) ? order_q[s+1] : order_q[s];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) order_q[i] <= IDW'(i);
        end else begin
            order_q <= order_after;
        end
    end

    always_comb begin
        present = '0;
        for (int i = 0; i < N; i++) present[order_q[i]] = 1'b1;
    end

    assert_queue_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(present) == N);
endmodule

// File: rtl/aba_pick.sv
module aba_pick #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic [N-1:0][IDW-1:0] order,
    input  logic [N-1:0]          req,
    output logic                  any,
    output logic [IDW-1:0]        win_id
);
    always_comb begin
        any    = 1'b0;
        win_id = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[order[i]]) begin
                any    = 1'b1;
                win_id = order[i];
            end
        end
    end

    always_comb begin
        if (any) assert_pick_requests_R2: assert (req[win_id]);
    end
endmodule

// File: rtl/aba_rpt_ctr.sv
module aba_rpt_ctr #(
    parameter int RPT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             dec,
    input  logic [RPT_W-1:0] limit,
    output logic             nonzero
);
    logic [RPT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      left_q <= '0;
        else if (reload) left_q <= limit;
        else if (dec)    left_q <= left_q - 1'b1;
    end

    assign nonzero = (left_q != '0);

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/aba_arbiter.sv
module aba_arbiter #(
    parameter int N_MST  = 4,
    parameter int CPU_ID = 0,
    parameter int RPT_W  = 4,
    localparam int IDW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req,
    input  logic [N_MST-1:0] rpt_hint,
    input  logic             ten_start,
    input  logic             retry,
    input  logic             retry_by_cpu,
    input  logic             cb_done,
    input  logic             cfg_park_en,
    input  logic [IDW-1:0]   cfg_park_id,
    input  logic [RPT_W-1:0] cfg_rpt_limit,
    input  logic             cfg_win_park_cpu,
    output logic [N_MST-1:0] gnt
);
    import aba_pkg::*;

    localparam logic [N_MST-1:0] CPU_VEC = N_MST'(1) << CPU_ID;

    aba_state_e state_q, state_n;
    logic [N_MST-1:0] gnt_n;
    logic [IDW-1:0]   last_id_q, last_id_n;
    logic [IDW-1:0]   saved_id_q, saved_id_n;
    logic [IDW-1:0]   owner_id;
    logic             gnt_any;
    logic             arb_state;
    logic             start, retry_ok, keep;
    logic             rpt_nz;
    logic             mv_en;
    logic [IDW-1:0]   mv_id;
    logic [N_MST-1:0][IDW-1:0] order_after;
    logic             pick_any;
    logic [IDW-1:0]   pick_id;
    logic [N_MST-1:0] park_vec;
    logic [N_MST-1:0] pick_vec;

    always_comb begin
        owner_id = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (gnt[i]) owner_id = IDW'(i);
        end
    end

    assign gnt_any   = |gnt;
    assign arb_state = (state_q == ST_IDLE) || (state_q == ST_OWN);
    assign retry_ok  = retry && arb_state;
    assign start     = ten_start && gnt_any && arb_state && !retry_ok;
    assign keep      = start && rpt_hint[owner_id] && req[owner_id] && rpt_nz;
    assign mv_en     = retry_ok ? !retry_by_cpu : (start && !keep);
    assign mv_id     = retry_ok ? last_id_q : owner_id;
    assign park_vec  = cfg_park_en ? (N_MST'(1) << cfg_park_id) : '0;
    assign pick_vec  = N_MST'(1) << pick_id;

    aba_prio_queue #(.N(N_MST), .IDW(IDW)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .mv_en       (mv_en),
        .mv_id       (mv_id),
        .order_after (order_after)
    );

    aba_pick #(.N(N_MST), .IDW(IDW)) u_pick (
        .order  (order_after),
        .req    (req),
        .any    (pick_any),
        .win_id (pick_id)
    );

    aba_rpt_ctr #(.RPT_W(RPT_W)) u_rpt (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  ((gnt_n != gnt) && (|gnt_n)),
        .dec     (keep),
        .limit   (cfg_rpt_limit),
        .nonzero (rpt_nz)
    );

    always_comb begin
        state_n    = state_q;
        gnt_n      = gnt;
        last_id_n  = last_id_q;
        saved_id_n = saved_id_q;
        unique case (state_q)
            ST_IDLE, ST_OWN: begin
                if (retry_ok) begin
                    if (retry_by_cpu) begin
                        state_n    = ST_CB;
                        gnt_n      = CPU_VEC;
                        saved_id_n = last_id_q;
                    end else begin
                        state_n = ST_WIN;
                        gnt_n   = cfg_win_park_cpu ? CPU_VEC : '0;
                    end
                end else if (start) begin
                    last_id_n = owner_id;
                    if (keep) begin
                        state_n = ST_OWN;
                    end else if (pick_any) begin
                        state_n = ST_OWN;
                        gnt_n   = pick_vec;
                    end else begin
                        state_n = ST_IDLE;
                        gnt_n   = park_vec;
                    end
                end else if (state_q == ST_IDLE) begin
                    if (pick_any) begin
                        state_n = ST_OWN;
                        gnt_n   = pick_vec;
                    end else begin
                        gnt_n   = park_vec;
                    end
                end
            end
            ST_WIN: begin
                if (pick_any) begin
                    state_n = ST_OWN;
                    gnt_n   = pick_vec;
                end else begin
                    state_n = ST_IDLE;
                    gnt_n   = park_vec;
                end
            end
            ST_CB: begin
                if (cb_done) begin
                    state_n = ST_OWN;
                    gnt_n   = N_MST'(1) << saved_id_q;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            last_id_q  <= '0;
            saved_id_q <= '0;
        end else begin
            state_q    <= state_n;
            last_id_q  <= last_id_n;
            saved_id_q <= saved_id_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gnt <= '0;
        else        gnt <= gnt_n;
    end

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_hold_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && !ten_start && !retry) |=> $stable(gnt));

    assert_window_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retry && !retry_by_cpu && arb_state) |=>
            (gnt == ($past(cfg_win_park_cpu) ? CPU_VEC : '0)));

    assert_cpu_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retry && retry_by_cpu && arb_state) |=> (gnt == CPU_VEC));

    assert_copyback_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CB && !cb_done) |=> $stable(gnt));
endmodule

// File: tb/aba_arbiter_bench.sv
module aba_arbiter_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] req, rpt_hint;
    logic       ten_start, retry, retry_by_cpu, cb_done;
    logic       cfg_park_en, cfg_win_park_cpu;
    logic [1:0] cfg_park_id;
    logic [3:0] cfg_rpt_limit;
    logic [3:0] gnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    aba_arbiter #(.N_MST(4), .CPU_ID(0), .RPT_W(4)) u_aba_arbiter (
        .clk(clk), .rst_n(rst_n), .req(req), .rpt_hint(rpt_hint),
        .ten_start(ten_start), .retry(retry), .retry_by_cpu(retry_by_cpu),
        .cb_done(cb_done), .cfg_park_en(cfg_park_en), .cfg_park_id(cfg_park_id),
        .cfg_rpt_limit(cfg_rpt_limit), .cfg_win_park_cpu(cfg_win_park_cpu),
        .gnt(gnt)
    );

    typedef struct packed {
        logic [3:0] rq;
        logic [3:0] hn;
        logic       st;
        logic       rt;
        logic       rc;
        logic       cb;
        logic [3:0] ex;
        logic [3:0] tag;
    } vec_t;

    // Fields: req, hint, start, retry, retry_by_cpu, cb_done, expected gnt, requirement.
    // Setup: park on master 2, repeat limit 2, no processor parking in the window.
    localparam vec_t VECS [21] = '{
        '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd5}, // R5 parked on 2
        '{4'b0101, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'd2}, // R2 0 wins
        '{4'b0101, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd2}, // R2 0 rotates, 2 wins
        '{4'b0101, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd3}, // R3 hold
        '{4'b0101, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd4}, // R4 repeat 1
        '{4'b0101, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd4}, // R4 repeat 2
        '{4'b0101, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 4'd4}, // R4 limit reached
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd5}, // R5 park after tenure
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd5}, // R5 parked master starts
        '{4'b1000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000, 4'd2}, // R2 3 wins
        '{4'b1010, 4'b1000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, 4'd4}, // R4 kept, no rotate
        '{4'b1010, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 4'd6}, // R6 window unparked
        '{4'b0010, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010, 4'd7}, // R7 window grant
        '{4'b1001, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 4'd6}, // R6 3 now behind 0
        '{4'b1001, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0001, 4'd3}, // R3 hold
        '{4'b1001, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, 4'd2}, // R2 3 wins
        '{4'b1000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b1000, 4'd2}, // R2 sole requester
        '{4'b0001, 4'b0000, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0001, 4'd8}, // R8 processor first
        '{4'b0001, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0001, 4'd8}, // R8 copyback holds
        '{4'b1000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b1, 4'b1000, 4'd8}, // R8 grant returned
        '{4'b0000, 4'b0000, 1'b1, 1'b0, 1'b0, 1'b0, 4'b0100, 4'd5}  // R5 park again
    };

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input int rq, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: gnt=%b expected=%b", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] r, input logic [3:0] h, input logic s,
                         input logic rt, input logic rc, input logic cb);
        @(negedge clk);
        req = r; rpt_hint = h; ten_start = s; retry = rt; retry_by_cpu = rc; cb_done = cb;
        @(posedge clk);
        #1;
    endtask

    initial begin
        rst_n = 1'b0;
        req = '0; rpt_hint = '0; ten_start = 1'b0; retry = 1'b0;
        retry_by_cpu = 1'b0; cb_done = 1'b0;
        cfg_park_en = 1'b1; cfg_park_id = 2'd2; cfg_rpt_limit = 4'd2; cfg_win_park_cpu = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(gnt, 4'b0000, 1, "reset value"); // R1
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(gnt, 4'b0100, 5, "first idle cycle parks"); // R5

        for (int i = 0; i < 21; i++) begin
            drive(VECS[i].rq, VECS[i].hn, VECS[i].st, VECS[i].rt, VECS[i].rc, VECS[i].cb);
            check(gnt, VECS[i].ex, int'(VECS[i].tag), $sformatf("vector %0d", i));
        end

        // Directed: parking off, repeat limit 0, processor parked in the window.
        cfg_park_en = 1'b0; cfg_rpt_limit = 4'd0; cfg_win_park_cpu = 1'b1;
        drive(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check(gnt, 4'b0000, 5, "parking disabled"); // R5
        drive(4'b0010, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check(gnt, 4'b0010, 2, "master 1 granted"); // R2
        drive(4'b0110, 4'b0010, 1'b1, 1'b0, 1'b0, 1'b0);
        check(gnt, 4'b0100, 4, "limit 0 ignores hint"); // R4
        drive(4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0);
        check(gnt, 4'b0001, 6, "window parks on processor"); // R6
        drive(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check(gnt, 4'b0000, 7, "after empty window no parking"); // R7
        drive(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0);
        check(gnt, 4'b0000, 1, "idle stays zero"); // R1

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog: gnt=%b expected=finished run", gnt);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule